// File: doc/BRIEF.md
# Clocked Burst Read Address Sequencer

This block is the synchronous read front end of a word-wide memory. It has a 16-bit data word and a 19-bit word address. A low load strobe at a rising clock edge captures a start address. After a fixed number of clock cycles, the word at that address comes out of a registered read port. A data-valid flag marks the word as good. From then on, each edge with the advance strobe low moves the output to the following word. The burst is 32 words long. After the last word it returns to the word it started from, not to an aligned boundary. An active-low end flag marks that last word. An edge with the advance strobe high leaves the output word unchanged.

The burst position is a 5-bit offset. It is added to the captured start address, modulo the full 19-bit address space. A new load at any time restarts the offset at zero.

The output bus is combinationally gated by three enables that have no clock relation: chip, output and write. The bus carries the word only while the enables select a read. Otherwise it carries zero and a drive flag is low, so a pad ring can turn the flag into a tri-state control.

The internal storage is a small preloaded array that is read through a registered port. It stands in for the memory core.

Top module: `burst_seq_top`

## Requirements
- R1: A cycle with `rst` high at a rising edge leaves `valid` low, `last_n` high and the offset at zero, and it drops any load still waiting out its latency.
- R2: With `load_n` low at a rising edge, `addr_in` becomes the burst start and the offset becomes zero. With `load_n` high, `addr_in` has no effect.
- R3: After a load edge, `valid` stays low until the (INIT_LAT-1)th following edge; after that edge it is high and the word at the start address is shown. With INIT_LAT=1 the word shows right after the load edge.
- R4: With `valid` high, `load_n` high and `adv_n` low at an edge, the offset steps by one. The next word is shown with `valid` high BURST_LAT-1 edges later; with BURST_LAT=1 it shows right after that edge.
- R5: With `valid` high and both strobes high at an edge, the word, `valid` and the offset stay unchanged.
- R6: `last_n` is low exactly when `valid` is high and the offset is 31.
- R7: An advance from offset 31 returns the output to the start word (offset 0).
- R8: The word address is (start + offset) modulo 2^19.
- R9: A load during a burst restarts the burst at the new address. A load takes priority over an advance at the same edge.
- R10: An advance strobe while `valid` is low, including while a load is waiting out its latency, has no effect.
- R11: `dq` shows the current word and `dq_drv` is high only while `ce_n`=0, `oe_n`=0 and `we_n`=1. Otherwise `dq` is 0 and `dq_drv` is 0. Both follow the enables with no clock.
- R12: The word stored at address A is {A[7:0] XOR 8'h5A, A[7:0]}, with the upper byte first. The array is indexed by the low 8 address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low start address capture strobe |
| adv_n | input | 1 | Active-low step-to-next-word strobe |
| addr_in | input | 19 | Burst start word address |
| ce_n | input | 1 | Active-low chip enable, asynchronous |
| oe_n | input | 1 | Active-low output enable, asynchronous |
| we_n | input | 1 | Active-low write enable, asynchronous; a low level blocks the read bus |
| dq | output | 16 | Gated read data |
| dq_drv | output | 1 | High while `dq` carries read data |
| valid | output | 1 | High while the registered word is good |
| last_n | output | 1 | Active-low end-of-burst marker (offset 31) |

## Verification
Some properties hold on every clock, and the assertions check those. A load clears the offset and captures the start address. An advance steps the offset by exactly one. A pending load or an idle cycle leaves the offset alone. The end marker appears only at offset 31 with valid high. The read register does not change without a read enable. Other behaviour shows only in the bench's scenarios, because it needs a value computed independently: the exact cycle in which the first word shows up, the data content at each address, the return to the start word after 31, the restart on a load in mid-burst, and the enable gating of the bus.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;
  // Stored content: address tag in low byte, scrambled tag in high byte (R12)
  function automatic logic [15:0] fill_word(input int unsigned idx);
    logic [7:0] t;
    t = idx[7:0];
    return {t ^ 8'h5A, t};
  endfunction
endpackage

// File: rtl/burst_ctrl.sv
`timescale 1ns/1ps
module burst_ctrl #(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 32,
  parameter int INIT_LAT  = 2,
  parameter int BURST_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              valid_o,
  output logic              last_n_o
);
  localparam int OFF_W   = $clog2(BURST_LEN);
  localparam int MAX_LAT = (INIT_LAT > BURST_LAT) ? INIT_LAT : BURST_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(BURST_LEN - 1);

  logic [ADDR_W-1:0] start_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  off_nxt;
  logic [CNT_W-1:0]  wait_q;
  logic              valid_q;
  logic              last_n_q;
  logic              do_load;
  logic              do_adv;
  logic              do_land;

  assign do_load = !load_n;
  assign do_adv  = load_n && !adv_n && valid_q;
  assign do_land = load_n && (wait_q == CNT_W'(1));
  assign off_nxt = off_q + 1'b1;

  always_comb begin
    if (do_load)
      rd_addr = addr_in;
    else if (do_adv)
      rd_addr = start_q + ADDR_W'(off_nxt);
    else
      rd_addr = start_q + ADDR_W'(off_q);
    rd_en = (do_load && INIT_LAT == 1) || (do_adv && BURST_LAT == 1) || do_land;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      off_q    <= '0;
      wait_q   <= '0;
      valid_q  <= 1'b0;
      last_n_q <= 1'b1;
    end else if (do_load) begin
      start_q  <= addr_in;
      off_q    <= '0;
      last_n_q <= 1'b1;
      if (INIT_LAT == 1) begin
        valid_q <= 1'b1;
        wait_q  <= '0;
      end else begin
        valid_q <= 1'b0;
        wait_q  <= CNT_W'(INIT_LAT - 1);
      end
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
      if (wait_q == CNT_W'(1)) begin
        valid_q  <= 1'b1;
        last_n_q <= !(off_q == OFF_MAX);
      end
    end else if (do_adv) begin
      off_q <= off_nxt;
      if (BURST_LAT == 1) begin
        valid_q  <= 1'b1;
        last_n_q <= !(off_nxt == OFF_MAX);
      end else begin
        valid_q  <= 1'b0;
        last_n_q <= 1'b1;
        wait_q   <= CNT_W'(BURST_LAT - 1);
      end
    end
  end

  assign valid_o  = valid_q;
  assign last_n_o = last_n_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> (off_q == '0 && start_q == $past(addr_in))); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (load_n && !adv_n && valid_q) |=> (off_q == OFF_W'($past(off_q) + 1'b1))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (load_n && adv_n && valid_q) |=> (valid_q && $stable(off_q) && $stable(start_q))); // R5
  AST_END_MARK: assert property (@(posedge clk) disable iff (rst)
    !last_n_q |-> (valid_q && off_q == OFF_MAX)); // R6
  AST_PEND_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (load_n && !valid_q) |=> $stable(off_q)); // R10
endmodule

// File: rtl/burst_rom.sv
`timescale 1ns/1ps
module burst_rom #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] word_o
);
  import burst_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(fill_word(i));
  end

  always_ff @(posedge clk) begin
    if (rst)
      word_o <= '0;
    else if (rd_en)
      word_o <= mem[rd_addr[IDX_W-1:0]];
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(word_o)); // R5
endmodule

// File: rtl/burst_bus.sv
`timescale 1ns/1ps
module burst_bus #(
  parameter int DATA_W = 16
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] dq,
  output logic              dq_drv
);
  always_comb begin
    dq_drv = !ce_n && !oe_n && we_n;
    dq     = dq_drv ? word_i : '0;
  end
endmodule

// File: rtl/burst_seq_top.sv
`timescale 1ns/1ps
module burst_seq_top #(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 32,
  parameter int INIT_LAT  = 2,
  parameter int BURST_LAT = 1,
  parameter int IDX_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic [DATA_W-1:0] dq,
  output logic              dq_drv,
  output logic              valid,
  output logic              last_n
);
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] word;

  burst_ctrl #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN),
               .INIT_LAT(INIT_LAT), .BURST_LAT(BURST_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .load_n(load_n), .adv_n(adv_n), .addr_in(addr_in),
    .rd_en(rd_en), .rd_addr(rd_addr), .valid_o(valid), .last_n_o(last_n)
  );

  burst_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rom (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .word_o(word)
  );

  burst_bus #(.DATA_W(DATA_W)) u_bus (
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .word_i(word),
    .dq(dq), .dq_drv(dq_drv)
  );
endmodule

// File: tb/burst_seq_top_test.sv
`timescale 1ns/1ps
module burst_seq_top_test;
  localparam int IL = 2;
  localparam int BL = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_n = 1'b1;
  logic        adv_n = 1'b1;
  logic [18:0] addr_in = '0;
  logic        ce_n = 1'b0;
  logic        oe_n = 1'b0;
  logic        we_n = 1'b1;
  logic [15:0] dq;
  logic        dq_drv;
  logic        valid;
  logic        last_n;

  int checks = 0;
  int failures = 0;

  logic [18:0] m_start = '0;
  int          m_off = 0;
  int          m_wait = 0;
  bit          m_valid = 1'b0;

  always #5 clk = ~clk;

  burst_seq_top uut (
    .clk(clk), .rst(rst), .load_n(load_n), .adv_n(adv_n), .addr_in(addr_in),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dq(dq), .dq_drv(dq_drv),
    .valid(valid), .last_n(last_n)
  );

  function automatic logic [15:0] exp_word(input logic [18:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_now(input string tag);
    logic [18:0] cur;
    bit          drv;
    cur = m_start + 19'(m_off);
    drv = !ce_n && !oe_n && we_n;
    chk(tag, "valid", 32'(valid), 32'(m_valid));
    chk("R6", "last_n", 32'(last_n), 32'(!(m_valid && m_off == 31)));
    chk("R11", "dq_drv", 32'(dq_drv), 32'(drv));
    if (!drv) chk("R11", "dq_off", 32'(dq), 32'h0);
    else if (m_valid) chk(tag, "dq_word", 32'(dq), 32'(exp_word(cur)));
  endtask

  task automatic model_edge(input bit r, input bit l, input bit a, input logic [18:0] ad);
    if (r) begin
      m_off = 0; m_wait = 0; m_valid = 0; m_start = '0;
    end else if (!l) begin
      m_start = ad; m_off = 0;
      if (IL == 1) begin m_valid = 1; m_wait = 0; end
      else begin m_valid = 0; m_wait = IL - 1; end
    end else if (m_wait != 0) begin
      m_wait--;
      if (m_wait == 0) m_valid = 1;
    end else if (!a && m_valid) begin
      m_off = (m_off + 1) % 32;
      if (BL == 1) m_valid = 1;
      else begin m_valid = 0; m_wait = BL - 1; end
    end
  endtask

  task automatic cyc(input string tag, input bit l, input bit a, input logic [18:0] ad,
                     input bit ce = 0, input bit oe = 0, input bit we = 1);
    load_n = l; adv_n = a; addr_in = ad; ce_n = ce; oe_n = oe; we_n = we;
    #1;
    check_now(tag);
    @(posedge clk);
    model_edge(rst, l, a, ad);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    model_edge(1, 1, 1, '0);
    // R1: reset state
    chk("R1", "valid_rst", 32'(valid), 32'h0);
    chk("R1", "last_n_rst", 32'(last_n), 32'h1);
    rst = 1'b0;

    // R2: load_n high, address ignored, nothing becomes valid
    cyc("R2", 1, 1, 19'h12345);
    cyc("R2", 1, 1, 19'h00077);
    // R3: load, then latency; R10: advance during pending ignored
    cyc("R3", 0, 1, 19'h00140);
    cyc("R10", 1, 0, 19'h00000);
    cyc("R3", 1, 1, 19'h00000);
    // R4 / R6 / R7: full burst and wrap
    for (int i = 0; i < 34; i++) cyc("R7", 1, 0, 19'h00000);
    // R5: hold
    for (int i = 0; i < 4; i++) cyc("R5", 1, 1, 19'h3FFFF);
    // R8: start near top of address space, wrap modulo 2^19
    cyc("R8", 0, 1, 19'h7FFF0);
    cyc("R8", 1, 1, 19'h0);
    for (int i = 0; i < 20; i++) cyc("R8", 1, 0, 19'h0);
    // R9: load in mid-burst, load beats advance
    cyc("R9", 0, 0, 19'h000A3);
    cyc("R9", 1, 0, 19'h0);
    cyc("R9", 1, 0, 19'h0);
    // R11: enable combinations
    cyc("R11", 1, 1, 19'h0, 1, 0, 1);
    cyc("R11", 1, 1, 19'h0, 0, 1, 1);
    cyc("R11", 1, 1, 19'h0, 0, 0, 0);
    cyc("R12", 1, 1, 19'h0, 0, 0, 1);
    // R1: reset mid-burst drops everything
    cyc("R4", 1, 0, 19'h0);
    rst = 1'b1;
    cyc("R1", 1, 0, 19'h0);
    rst = 1'b0;
    cyc("R1", 1, 0, 19'h0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit l, a, ce, oe, we;
      l  = ($urandom % 10) != 0;
      a  = ($urandom % 3) == 0;
      ce = ($urandom % 8) == 0;
      oe = ($urandom % 8) == 0;
      we = ($urandom % 10) != 0;
      cyc("R4", l, a, 19'($urandom), ce, oe, we);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule